// File: doc/BRIEF.md
# Amplifier Output-Stage Protection Controller

This block guards a power amplifier's output stage against overheating and shorted outputs. It takes a digitized die-temperature code and a one-bit short-detect flag. From these it drives three outputs: a request to lower the amplifier's internal gain, an enable for the output stage, and a single fault flag for the system to monitor.

Heat is handled in two steps. A warm die first gets a gain-reduction request. A die that keeps heating has its output stage switched off completely. Both steps release only once the die has cooled well below the point that set them.

A short to either rail, or across the load, turns the output stage off for a fixed hiccup interval. The stage is then switched on again as a retry. If the short is still there, the off interval starts again, and this repeats until the short clears. A global enable input clears both protection paths whenever it is low.

Top module: `amp_guard`

## Requirements
- R1: While `rst_n` is low the gain request and fault flag are 0; after reset with `run_en_i` high, a cool die (code below 150) and no short, `stage_en_o` is 1 and both other outputs are 0.
- R2: A temperature code of 150 or more (one code = 1 °C) raises `gain_cut_o` one cycle later; it stays high for codes 131..149 and drops one cycle after a code of 130 or less.
- R3: A code above 160 turns the stage off (`stage_en_o` 0, `fault_o` 1) one cycle later, both from the gain-reduced state and directly from the normal state; `gain_cut_o` stays 1 while the stage is off for heat.
- R4: After a thermal shutdown, codes 131..160 keep the stage off; a code of 130 or less restores `stage_en_o` 1 and clears `fault_o` and `gain_cut_o` one cycle later.
- R5: A short seen while the stage is on drops `stage_en_o` and raises `fault_o` on the next cycle, for exactly `HICCUP_CYC` cycles, after which the stage is on again.
- R6: If the short is still present when the stage is retried, the next cycle starts another full off interval; this repeats without limit.
- R7: The short input has no effect while the stage is off, whether for a hiccup interval or for heat: it neither lengthens the interval nor starts a new one.
- R8: A thermal shutdown keeps the stage off even when the hiccup interval has ended; `fault_o` is high whenever the stage is off with `run_en_i` high.
- R9: With `run_en_i` low, `stage_en_o` is 0 in the same cycle, and on the next cycle both protection paths are cleared (`gain_cut_o` 0, `fault_o` 0), whatever the temperature or short input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| run_en_i | input | 1 | Global amplifier enable; low clears all protection |
| temp_i | input | TEMP_W | Die temperature code, 1 °C per step |
| short_i | input | 1 | Output short detected (any kind) |
| gain_cut_o | output | 1 | Request to reduce internal gain |
| stage_en_o | output | 1 | Output stage enable |
| fault_o | output | 1 | Thermal shutdown or short-circuit wait in progress |

## Verification
A thermal state stuck in or skipping the gain-reduced stage is visible one cycle after the temperature code crosses 150, 160 or 130. The gain request or the stage enable then disagrees with a cycle-by-cycle model driven by ramps across every code. A wrong hiccup count, or a short sampled while the stage is off, shows as a stage enable returning one or more cycles early or late within a single interval. A lost clear on the global enable shows as a stale fault on the first cycle after the enable returns.

// File: rtl/guard_pkg.sv
// Shared state encodings for the amplifier protection controller.
// Assumes: used by therm_grader, hiccup_timer and amp_guard only.
package guard_pkg;
    typedef enum logic [1:0] {
        TH_NORM = 2'd0,
        TH_CUT  = 2'd1,
        TH_OFF  = 2'd2
    } therm_st_t;

    typedef enum logic {
        HC_RUN  = 1'b0,
        HC_WAIT = 1'b1
    } hic_st_t;
endpackage

// File: rtl/therm_grader.sv
// Two-tier thermal response: gain reduction, then full shutdown, with
// hysteresis on release. Assumes an unsigned temperature code, 1 degree/LSB,
// and thresholds ordered REC_LVL < CUT_LVL <= OFF_LVL.
module therm_grader
    import guard_pkg::*;
#(
    parameter int TEMP_W  = 8,
    parameter int CUT_LVL = 150,
    parameter int OFF_LVL = 160,
    parameter int REC_LVL = 130
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic [TEMP_W-1:0] temp,
    output logic              gain_cut,
    output logic              therm_off
);
    localparam logic [TEMP_W-1:0] CUT_C = TEMP_W'(CUT_LVL);
    localparam logic [TEMP_W-1:0] OFF_C = TEMP_W'(OFF_LVL);
    localparam logic [TEMP_W-1:0] REC_C = TEMP_W'(REC_LVL);

    therm_st_t state_q, state_d;
    logic      hot, warm, cooled;

    // Threshold comparators against the current code.
    always_comb begin
        hot    = temp > OFF_C;
        warm   = temp >= CUT_C;
        cooled = temp <= REC_C;
    end

    // Next-state selection for the thermal tiers.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TH_NORM: if (hot) state_d = TH_OFF;
                     else if (warm) state_d = TH_CUT;
            TH_CUT:  if (hot) state_d = TH_OFF;
                     else if (cooled) state_d = TH_NORM;
            TH_OFF:  if (cooled) state_d = TH_NORM;
            default: state_d = TH_NORM;
        endcase
        if (!run_en) state_d = TH_NORM;
    end

    // Thermal state register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TH_NORM;
        else        state_q <= state_d;
    end

    assign gain_cut  = (state_q != TH_NORM);
    assign therm_off = (state_q == TH_OFF);

    a_r3_hot_shuts_off: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && temp > OFF_C) |=> therm_off);
    a_r4_hold_until_cool: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && therm_off && temp > REC_C) |=> therm_off);
    a_r2_hold_cut: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && gain_cut && temp > REC_C) |=> gain_cut);
    a_r9_thermal_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> !gain_cut);
endmodule

// File: rtl/hiccup_timer.sv
// Hiccup-mode short handling: a short seen while the stage may run starts a
// fixed off interval of HICCUP_CYC cycles, then the stage is retried.
// Assumes HICCUP_CYC >= 2; short_det is only honoured while sample_ok is high.
module hiccup_timer
    import guard_pkg::*;
#(
    parameter int HICCUP_CYC = 36_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_en,
    input  logic sample_ok,
    input  logic short_det,
    output logic waiting
);
    localparam int CNT_W = $clog2(HICCUP_CYC);
    localparam logic [CNT_W-1:0] LOAD_V = CNT_W'(HICCUP_CYC - 1);

    hic_st_t          st_q;
    logic [CNT_W-1:0] cnt_q;

    // Wait-state and countdown register; short sampled only in run state.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_en) begin
            st_q  <= HC_RUN;
            cnt_q <= '0;
        end else if (st_q == HC_WAIT) begin
            if (cnt_q == '0) st_q <= HC_RUN;
            else             cnt_q <= cnt_q - 1'b1;
        end else if (short_det && sample_ok) begin
            st_q  <= HC_WAIT;
            cnt_q <= LOAD_V;
        end
    end

    assign waiting = (st_q == HC_WAIT);

    a_r5_enter_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !waiting && sample_ok && short_det) |=> waiting);
    a_r7_wait_not_extended: assert property (@(posedge clk) disable iff (!rst_n)
        (waiting && cnt_q == '0) |=> !waiting);
    a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LOAD_V);
    a_r7_count_moves: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && waiting && cnt_q != '0) |=> (waiting && cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/amp_guard.sv
// Top of the output-stage protection controller: combines the thermal tiers
// and the hiccup timer into gain-reduce, stage-enable and fault outputs.
// Assumes temperature and short inputs are already synchronous to clk.
module amp_guard #(
    parameter int TEMP_W     = 8,
    parameter int CUT_LVL    = 150,
    parameter int OFF_LVL    = 160,
    parameter int REC_LVL    = 130,
    parameter int HICCUP_CYC = 36_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en_i,
    input  logic [TEMP_W-1:0] temp_i,
    input  logic              short_i,
    output logic              gain_cut_o,
    output logic              stage_en_o,
    output logic              fault_o
);
    logic therm_off, hic_wait, may_run;

    therm_grader #(
        .TEMP_W (TEMP_W),
        .CUT_LVL(CUT_LVL),
        .OFF_LVL(OFF_LVL),
        .REC_LVL(REC_LVL)
    ) u_therm (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_en   (run_en_i),
        .temp     (temp_i),
        .gain_cut (gain_cut_o),
        .therm_off(therm_off)
    );

    // Thermal shutdown wins: shorts are not sampled while it holds the stage off.
    assign may_run = run_en_i & ~therm_off;

    hiccup_timer #(
        .HICCUP_CYC(HICCUP_CYC)
    ) u_hic (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_en   (run_en_i),
        .sample_ok(may_run),
        .short_det(short_i),
        .waiting  (hic_wait)
    );

    assign stage_en_o = may_run & ~hic_wait;
    assign fault_o    = therm_off | hic_wait;

    a_r8_thermal_priority: assert property (@(posedge clk) disable iff (!rst_n)
        therm_off |-> !stage_en_o);
    a_r8_fault_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en_i && !stage_en_o) |-> fault_o);
    a_r9_fault_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en_i |=> !fault_o);
    a_r9_stage_off: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en_i |-> !stage_en_o);
endmodule

// File: tb/amp_guard_tb.sv
`timescale 1ns/1ps
module amp_guard_tb;
    localparam int H = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [7:0] temp = 8'd25;
    logic       shrt = 1'b0;
    logic       gain_cut, stage_en, fault;

    int vec = 0;
    int bad = 0;
    bit done = 1'b0;

    // model state
    int  m_th = 0;
    bit  m_wait = 1'b0;
    int  m_cnt = 0;

    always #2.5 clk = ~clk;

    amp_guard #(.TEMP_W(8), .CUT_LVL(150), .OFF_LVL(160), .REC_LVL(130),
                .HICCUP_CYC(H)) u_dut (
        .clk(clk), .rst_n(rst_n), .run_en_i(en), .temp_i(temp), .short_i(shrt),
        .gain_cut_o(gain_cut), .stage_en_o(stage_en), .fault_o(fault));

    task automatic chk(input string tag, input logic act, input logic exp);
        vec++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // Advance one cycle from a negedge: drive, clock, update model, compare.
    task automatic step(input logic e, input int t, input logic s);
        bit stage_now;
        en = e; temp = 8'(t); shrt = s;
        @(posedge clk);
        if (!rst_n || !e) begin
            m_th = 0; m_wait = 1'b0; m_cnt = 0;
        end else begin
            stage_now = (m_th != 2) && !m_wait;
            if (m_wait) begin
                if (m_cnt == 0) m_wait = 1'b0; else m_cnt--;
            end else if (s && stage_now) begin
                m_wait = 1'b1; m_cnt = H - 1;
            end
            case (m_th)
                0: if (t > 160) m_th = 2; else if (t >= 150) m_th = 1;
                1: if (t > 160) m_th = 2; else if (t <= 130) m_th = 0;
                default: if (t <= 130) m_th = 0;
            endcase
        end
        @(negedge clk);
        chk("R2 gain model", gain_cut, m_th != 0);
        chk("R8 stage model", stage_en, en && m_th != 2 && !m_wait);
        chk("R6 fault model", fault, m_th == 2 || m_wait);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++;
            vec++;
            $display("FAIL watchdog: got hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
            $finish;
        end
    end

    initial begin : main
        int lfsr;
        @(negedge clk);
        // R1: reset state
        step(1'b1, 25, 1'b0);
        step(1'b1, 25, 1'b0);
        chk("R1 gain in reset", gain_cut, 1'b0);
        chk("R1 fault in reset", fault, 1'b0);
        rst_n = 1'b1;
        step(1'b1, 25, 1'b0);
        chk("R1 stage after reset", stage_en, 1'b1);

        // R2: gain reduction with hysteresis
        step(1'b1, 149, 1'b0); chk("R2 below cut", gain_cut, 1'b0);
        step(1'b1, 150, 1'b0); chk("R2 at cut", gain_cut, 1'b1);
        step(1'b1, 131, 1'b0); chk("R2 hold at 131", gain_cut, 1'b1);
        step(1'b1, 130, 1'b0); chk("R2 release at 130", gain_cut, 1'b0);

        // R3: shutdown from reduced and from normal
        step(1'b1, 155, 1'b0);
        step(1'b1, 160, 1'b0); chk("R3 160 not off", stage_en, 1'b1);
        step(1'b1, 161, 1'b0); chk("R3 off from cut", stage_en, 1'b0);
        chk("R3 fault", fault, 1'b1); chk("R3 gain held", gain_cut, 1'b1);
        step(1'b1, 100, 1'b0);
        step(1'b1, 200, 1'b0); chk("R3 off from normal", stage_en, 1'b0);

        // R4: hysteresis on release
        step(1'b1, 160, 1'b0); chk("R4 hold 160", stage_en, 1'b0);
        step(1'b1, 131, 1'b0); chk("R4 hold 131", stage_en, 1'b0);
        step(1'b1, 130, 1'b0); chk("R4 restore", stage_en, 1'b1);
        chk("R4 fault clear", fault, 1'b0); chk("R4 gain clear", gain_cut, 1'b0);

        // R5: one hiccup interval
        step(1'b1, 40, 1'b1); chk("R5 enter", stage_en, 1'b0); chk("R5 fault", fault, 1'b1);
        for (int k = 1; k < H; k++) begin
            step(1'b1, 40, 1'b0); chk("R5 still off", stage_en, 1'b0);
        end
        step(1'b1, 40, 1'b0); chk("R5 retry", stage_en, 1'b1); chk("R5 fault low", fault, 1'b0);

        // R7 + R6: short held through interval, then persistent
        step(1'b1, 40, 1'b1);
        for (int k = 1; k < H; k++) step(1'b1, 40, 1'b1);
        step(1'b1, 40, 1'b1); chk("R7 interval not extended", stage_en, 1'b1);
        step(1'b1, 40, 1'b1); chk("R6 re-enter wait", stage_en, 1'b0);
        for (int k = 1; k < H; k++) step(1'b1, 40, 1'b1);
        step(1'b1, 40, 1'b0); chk("R6 second retry", stage_en, 1'b1);

        // R7: short during thermal shutdown ignored
        step(1'b1, 170, 1'b0);
        step(1'b1, 170, 1'b1);
        step(1'b1, 170, 1'b1);
        step(1'b1, 120, 1'b0); chk("R7 no pending hiccup", stage_en, 1'b1);
        chk("R7 fault clear", fault, 1'b0);

        // R8: thermal keeps stage off after hiccup ends
        step(1'b1, 40, 1'b1);
        step(1'b1, 170, 1'b0);
        for (int k = 0; k < H + 2; k++) step(1'b1, 170, 1'b0);
        chk("R8 thermal holds off", stage_en, 1'b0); chk("R8 fault", fault, 1'b1);
        step(1'b1, 120, 1'b0); chk("R8 restore", stage_en, 1'b1);

        // R9: global enable clears both paths
        step(1'b1, 40, 1'b1);
        step(1'b1, 170, 1'b0);
        step(1'b0, 170, 1'b1); chk("R9 stage off", stage_en, 1'b0);
        chk("R9 gain clear", gain_cut, 1'b0); chk("R9 fault clear", fault, 1'b0);
        step(1'b1, 40, 1'b0); chk("R9 back on", stage_en, 1'b1);

        // Sweep: ramps across all codes with pseudo-random shorts and enables
        lfsr = 32'h1ACE;
        for (int pass = 0; pass < 4; pass++) begin
            for (int t = 0; t < 512; t++) begin
                int code;
                lfsr = (lfsr * 1103515245 + 12345) & 32'h7FFF_FFFF;
                code = (t < 256) ? t : 511 - t;
                step(((lfsr >> 20) % 53) != 0, code, ((lfsr >> 8) % (3 + pass * 4)) == 0);
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end
endmodule